// File: doc/BRIEF.md
# Interrupt Vector Responder

This block is a bus slave placed next to one external interrupt source. It keeps a pending flag for that source and watches the bus for the special read transfer a processor issues when it acknowledges an interrupt. That transfer is recognised by its transfer type, an attribute bit, the read direction and an address made of a fixed pattern with the priority level placed in three middle bits. When the level matches the level configured for this responder, the block places its configured 8-bit vector number on the most significant byte lane of the data bus. It then pulses transfer-acknowledge for one clock.

A programmable number of wait states can be inserted before the acknowledge. In vectored mode the acknowledge also clears the pending flag. In autovector mode the processor never runs the acknowledge transfer on the bus, so the responder ignores matching transfers and the flag is cleared only by a software clear pulse.

Top module: `ivr_responder`

## Requirements
- R1: While reset is asserted and after its release, `ta` is 0, `d_oe` is 4'b0000 and `irq_pending` is 0 until a raise pulse is seen.
- R2: A transfer is an acknowledge for this responder when `ts`=1, `tt`=2'b11, `atm`=1, `rw`=1 (1 means read), `addr[27:5]` are all ones, `addr[1:0]`=2'b00, `addr[4:2]` equals `cfg_level` and `cfg_autovec`=0.
- R3: If the rising edge that samples a matching `ts` is edge k, `ta` is high for exactly one cycle, starting at edge k+`cfg_wait`.
- R4: While `ta` is high, `d_oe`=4'b1000 (bit 3 enables byte lane D[31:24]) and `d_out[31:24]` equals `cfg_vector`. Otherwise `d_oe` is 4'b0000. Lanes D[23:0] are never enabled.
- R5: A transfer with a wrong level, a wrong type, `atm`=0, `rw`=0 or a wrong fixed address bit produces no `ta` and leaves `irq_pending` unchanged.
- R6: A one-cycle `irq_raise` pulse sets `irq_pending` at the next rising edge.
- R7: In vectored mode `irq_pending` clears on the edge where `ta` rises.
- R8: With `cfg_autovec`=1, a matching transfer gets no `ta` and `irq_pending` stays set.
- R9: A `sw_clear` pulse clears `irq_pending` in either mode. When `irq_raise` and `sw_clear` arrive in the same cycle, the raise wins.
- R10: A start strobe that arrives while a response is still in its wait or acknowledge cycle is ignored, so only one `ta` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 3 | Priority level this responder answers for |
| cfg_vector | input | 8 | Vector number returned on an acknowledge |
| cfg_autovec | input | 1 | 1 = autovector mode, no bus response |
| cfg_wait | input | 4 | Wait states inserted before `ta` |
| irq_raise | input | 1 | Pulse that sets the pending flag |
| sw_clear | input | 1 | Software clear pulse for the pending flag |
| ts | input | 1 | Transfer-start strobe |
| tt | input | 2 | Transfer type |
| atm | input | 1 | Attribute bit, 1 during an acknowledge start |
| rw | input | 1 | Direction, 1 = read |
| addr | input | 28 | Address bus |
| ta | output | 1 | Transfer-acknowledge pulse |
| d_out | output | 32 | Data driven toward the bus |
| d_oe | output | 4 | Per-byte-lane output enable, bit 3 = D[31:24] |
| irq_pending | output | 1 | Pending interrupt request |

## Verification
If the wait counter is loaded wrongly, `ta` moves away from edge k+`cfg_wait`. A stuck state register shows up as a missing or doubled pulse within a few cycles of the start strobe. A flag that clears at the wrong moment, or on a rejected transfer, is visible on `irq_pending` at the cycle right after that transfer. A decode fault appears either as an unexpected `ta` that finds the scoreboard empty, or as a scoreboard entry that `ta` never arrives to consume.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } ivr_state_e;

  localparam logic [1:0] TT_IACK = 2'b11;
  localparam int         LANE_W  = 8;
endpackage

// File: rtl/ivr_decode.sv
module ivr_decode #(
  parameter int ADDR_W  = 28,
  parameter int LEVEL_W = 3
) (
  input  logic               ts,
  input  logic [1:0]         tt,
  input  logic               atm,
  input  logic               rw,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LEVEL_W-1:0] cfg_level,
  input  logic               cfg_autovec,
  output logic               hit
);
  import ivr_pkg::*;

  localparam int LVL_LO = 2;
  localparam int LVL_HI = LVL_LO + LEVEL_W - 1;

  logic type_ok;
  logic ones_ok;
  logic zero_ok;
  logic lvl_ok;

  always_comb begin
    type_ok = (tt == TT_IACK) && atm && rw;
    ones_ok = &addr[ADDR_W-1:LVL_HI+1];
    zero_ok = (addr[LVL_LO-1:0] == '0);
    lvl_ok  = (addr[LVL_HI:LVL_LO] == cfg_level);
    hit     = ts && type_ok && ones_ok && zero_ok && lvl_ok && !cfg_autovec;
  end
endmodule

// File: rtl/ivr_timer.sv
module ivr_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              cfg_autovec,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              ack_entry,
  output logic              ta
);
  import ivr_pkg::*;

  ivr_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hit) begin
          if (cfg_wait == '0) begin
            state_d = ST_ACK;
          end else begin
            state_d = ST_WAIT;
            cnt_d   = cfg_wait - WAIT_W'(1);
            cnt_en  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (cfg_autovec) begin
          state_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          state_d = ST_ACK;
        end else begin
          cnt_d  = cnt_q - WAIT_W'(1);
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ack_entry = (state_d == ST_ACK);
  assign ta        = (state_q == ST_ACK);
endmodule

// File: rtl/ivr_pending.sv
module ivr_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic sw_clear,
  input  logic ack_clear,
  output logic pending
);
  logic pend_q, pend_d;

  always_comb begin
    if (raise) begin
      pend_d = 1'b1;
    end else if (sw_clear || ack_clear) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/ivr_lanes.sv
module ivr_lanes #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic                               drive,
  input  logic [VEC_W-1:0]                   vector,
  output logic [DATA_W-1:0]                  d_out,
  output logic [DATA_W/ivr_pkg::LANE_W-1:0]  d_oe
);
  import ivr_pkg::*;

  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    if (g == NUM_LANES - 1) begin : g_top
      assign d_out[g*LANE_W +: LANE_W] = drive ? LANE_W'(vector) : '0;
      assign d_oe[g]                   = drive;
    end else begin : g_idle
      assign d_out[g*LANE_W +: LANE_W] = '0;
      assign d_oe[g]                   = 1'b0;
    end
  end
endmodule

// File: rtl/ivr_responder.sv
module ivr_responder #(
  parameter int ADDR_W  = 28,
  parameter int LEVEL_W = 3,
  parameter int VEC_W   = 8,
  parameter int WAIT_W  = 4,
  parameter int DATA_W  = 32,
  localparam int LANES  = DATA_W / ivr_pkg::LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] cfg_level,
  input  logic [VEC_W-1:0]   cfg_vector,
  input  logic               cfg_autovec,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               irq_raise,
  input  logic               sw_clear,
  input  logic               ts,
  input  logic [1:0]         tt,
  input  logic               atm,
  input  logic               rw,
  input  logic [ADDR_W-1:0]  addr,
  output logic               ta,
  output logic [DATA_W-1:0]  d_out,
  output logic [LANES-1:0]   d_oe,
  output logic               irq_pending
);
  logic hit;
  logic ack_entry;

  ivr_decode #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_decode (
    .ts          (ts),
    .tt          (tt),
    .atm         (atm),
    .rw          (rw),
    .addr        (addr),
    .cfg_level   (cfg_level),
    .cfg_autovec (cfg_autovec),
    .hit         (hit)
  );

  ivr_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .cfg_autovec (cfg_autovec),
    .cfg_wait    (cfg_wait),
    .ack_entry   (ack_entry),
    .ta          (ta)
  );

  ivr_pending u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (irq_raise),
    .sw_clear  (sw_clear),
    .ack_clear (ack_entry),
    .pending   (irq_pending)
  );

  ivr_lanes #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_lanes (
    .drive  (ta),
    .vector (cfg_vector),
    .d_out  (d_out),
    .d_oe   (d_oe)
  );
endmodule

// File: rtl/ivr_responder_chk.sv
module ivr_responder_chk #(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VEC_W-1:0]  cfg_vector,
  input logic              cfg_autovec,
  input logic              irq_raise,
  input logic              sw_clear,
  input logic              ta,
  input logic [DATA_W-1:0] d_out,
  input logic [LANES-1:0]  d_oe,
  input logic              irq_pending
);
  // R3: acknowledge lasts a single cycle
  p_ta_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> !ta);

  // R4: top lane carries the vector only while acknowledging
  p_lane_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ta |-> (d_oe == LANES'(1) << (LANES - 1)) && (d_out[DATA_W-1 -: VEC_W] == cfg_vector));

  p_lane_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ta |-> (d_oe == '0));

  // R5: without raise, clear or a new acknowledge the flag holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_raise && !sw_clear) |=> ($stable(irq_pending) || $rose(ta)));

  // R6: raise sets the flag
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |=> irq_pending);

  // R7: flag clears where the acknowledge begins
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ta) && !$past(irq_raise)) |-> !irq_pending);

  // R8: no acknowledge may start out of autovector mode
  p_autovec_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ta) |-> !$past(cfg_autovec));

  // R9: software clear empties the flag unless raise coincides
  p_swclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !irq_raise) |=> !irq_pending);
endmodule

bind ivr_responder ivr_responder_chk #(
  .VEC_W  (VEC_W),
  .DATA_W (DATA_W),
  .LANES  (LANES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_vector  (cfg_vector),
  .cfg_autovec (cfg_autovec),
  .irq_raise   (irq_raise),
  .sw_clear    (sw_clear),
  .ta          (ta),
  .d_out       (d_out),
  .d_oe        (d_oe),
  .irq_pending (irq_pending)
);

// File: tb/ivr_responder_bench.sv
module ivr_responder_bench;
  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_level;
  logic [7:0]  cfg_vector;
  logic        cfg_autovec;
  logic [3:0]  cfg_wait;
  logic        irq_raise;
  logic        sw_clear;
  logic        ts;
  logic [1:0]  tt;
  logic        atm;
  logic        rw;
  logic [27:0] addr;
  logic        ta;
  logic [31:0] d_out;
  logic [3:0]  d_oe;
  logic        irq_pending;

  ivr_responder u_ivr_responder (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_level   (cfg_level),
    .cfg_vector  (cfg_vector),
    .cfg_autovec (cfg_autovec),
    .cfg_wait    (cfg_wait),
    .irq_raise   (irq_raise),
    .sw_clear    (sw_clear),
    .ts          (ts),
    .tt          (tt),
    .atm         (atm),
    .rw          (rw),
    .addr        (addr),
    .ta          (ta),
    .d_out       (d_out),
    .d_oe        (d_oe),
    .irq_pending (irq_pending)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit done   = 0;

  always @(posedge clk) edges <= edges + 1;

  typedef struct packed {
    int         cyc;
    logic [7:0] vec;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses as ta appears
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ta) begin
        if (sb.size() == 0) begin
          chk("R5/R8/R10 unexpected ta", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R3 ta cycle", edges, e.cyc);
          chk("R4 vector on D[31:24]", {24'd0, d_out[31:24]}, {24'd0, e.vec});
          chk("R4 lane enables", {28'd0, d_oe}, 32'h8);
          chk("R4 low lanes quiet", {8'd0, d_out[23:0]}, 32'd0);
        end
      end else if (d_oe != 4'd0) begin
        chk("R4 enable without ta", {28'd0, d_oe}, 32'd0);
      end
    end
  end

  function automatic logic [27:0] iack_addr(input logic [2:0] lvl);
    return {23'h7FFFFF, lvl, 2'b00};
  endfunction

  task automatic bus_cycle(input logic [2:0] lvl_unused, input logic [1:0] t, input logic a,
                           input logic r, input logic [27:0] ad, input bit expect_resp,
                           input bit hold_two);
    exp_t e;
    @(negedge clk);
    ts = 1'b1; tt = t; atm = a; rw = r; addr = ad;
    if (expect_resp) begin
      e.cyc = edges + 1 + int'(cfg_wait);
      e.vec = cfg_vector;
      sb.push_back(e);
    end
    if (hold_two) @(negedge clk);
    @(negedge clk);
    ts = 1'b0; tt = 2'b00; atm = 1'b0; rw = 1'b0; addr = '0;
    repeat (int'(cfg_wait) + 3) @(negedge clk);
  endtask

  task automatic pulse_raise();
    @(negedge clk); irq_raise = 1'b1;
    @(negedge clk); irq_raise = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); sw_clear = 1'b1;
    @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    chk("watchdog expired", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_level = 3'd5; cfg_vector = 8'hA7; cfg_autovec = 1'b0; cfg_wait = 4'd0;
    irq_raise = 1'b0; sw_clear = 1'b0;
    ts = 1'b0; tt = 2'b00; atm = 1'b0; rw = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 ta in reset", {31'd0, ta}, 32'd0);
    chk("R1 d_oe in reset", {28'd0, d_oe}, 32'd0);
    chk("R1 pending in reset", {31'd0, irq_pending}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pending after release", {31'd0, irq_pending}, 32'd0);

    // R6 then R2/R7 with no wait states
    pulse_raise();
    chk("R6 raise sets pending", {31'd0, irq_pending}, 32'd1);
    bus_cycle(3'd5, 2'b11, 1'b1, 1'b1, iack_addr(3'd5), 1'b1, 1'b0);
    chk("R7 ack clears pending", {31'd0, irq_pending}, 32'd0);

    // R5 mismatches
    pulse_raise();
    bus_cycle(3'd0, 2'b11, 1'b1, 1'b1, iack_addr(3'd4), 1'b0, 1'b0);
    chk("R5 wrong level keeps pending", {31'd0, irq_pending}, 32'd1);
    bus_cycle(3'd0, 2'b10, 1'b1, 1'b1, iack_addr(3'd5), 1'b0, 1'b0);
    chk("R5 wrong type keeps pending", {31'd0, irq_pending}, 32'd1);
    bus_cycle(3'd0, 2'b11, 1'b0, 1'b1, iack_addr(3'd5), 1'b0, 1'b0);
    chk("R5 atm low keeps pending", {31'd0, irq_pending}, 32'd1);
    bus_cycle(3'd0, 2'b11, 1'b1, 1'b0, iack_addr(3'd5), 1'b0, 1'b0);
    chk("R5 write keeps pending", {31'd0, irq_pending}, 32'd1);
    bus_cycle(3'd0, 2'b11, 1'b1, 1'b1, iack_addr(3'd5) & ~28'h400, 1'b0, 1'b0);
    chk("R5 high address bit keeps pending", {31'd0, irq_pending}, 32'd1);
    bus_cycle(3'd0, 2'b11, 1'b1, 1'b1, iack_addr(3'd5) | 28'h1, 1'b0, 1'b0);
    chk("R5 low address bit keeps pending", {31'd0, irq_pending}, 32'd1);

    // R3 with two wait states, different level and vector
    cfg_wait = 4'd2; cfg_level = 3'd2; cfg_vector = 8'h3C;
    bus_cycle(3'd2, 2'b11, 1'b1, 1'b1, iack_addr(3'd2), 1'b1, 1'b0);
    chk("R7 ack after waits clears pending", {31'd0, irq_pending}, 32'd0);

    // R10 strobe repeated during wait states
    cfg_wait = 4'd3;
    pulse_raise();
    bus_cycle(3'd2, 2'b11, 1'b1, 1'b1, iack_addr(3'd2), 1'b1, 1'b1);
    chk("R10 single response, pending cleared", {31'd0, irq_pending}, 32'd0);

    // R8 autovector mode
    cfg_wait = 4'd0; cfg_autovec = 1'b1;
    pulse_raise();
    bus_cycle(3'd2, 2'b11, 1'b1, 1'b1, iack_addr(3'd2), 1'b0, 1'b0);
    chk("R8 autovec keeps pending", {31'd0, irq_pending}, 32'd1);
    pulse_clear();
    chk("R9 sw clear empties pending", {31'd0, irq_pending}, 32'd0);

    // R9 raise beats clear
    @(negedge clk); irq_raise = 1'b1; sw_clear = 1'b1;
    @(negedge clk); irq_raise = 1'b0; sw_clear = 1'b0;
    chk("R9 raise wins over clear", {31'd0, irq_pending}, 32'd1);
    cfg_autovec = 1'b0;
    pulse_clear();
    chk("R9 clear in vectored mode", {31'd0, irq_pending}, 32'd0);

    // R2 level and vector extremes
    cfg_level = 3'd7; cfg_vector = 8'hFF; cfg_wait = 4'd1;
    bus_cycle(3'd7, 2'b11, 1'b1, 1'b1, iack_addr(3'd7), 1'b1, 1'b0);
    cfg_level = 3'd0; cfg_vector = 8'h00; cfg_wait = 4'd15;
    bus_cycle(3'd0, 2'b11, 1'b1, 1'b1, iack_addr(3'd0), 1'b1, 1'b0);

    repeat (4) @(negedge clk);
    chk("R2 every expected response seen", sb.size(), 32'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule